// File: doc/BRIEF.md
# Overlay Configuration Register Bank with Two-Wire Slave Port

This block holds the configuration words of a picture-in-picture overlay engine and exposes them to a host through a slave-only two-wire serial port in the I2C style. The host sends the write address, a register index and one or more data bytes. Each byte is acknowledged, and the index advances after every data byte. A read transfer returns one status byte that carries a write-pending flag and the overlay sync-detect flag.

The serial clock and data lines are oversampled by the system clock. Start and stop conditions are detected from the sampled lines, and the open-drain data line is modelled as a drive-low enable. Incoming data bytes land in a shadow bank. The live bank that drives the video logic copies the whole shadow bank on the active edge of the vertical reference, so a frame never shows a half-updated configuration. Register 03h bit 6 selects which edge of the vertical reference is active. A few decoded fields are brought out beside the flat live bank.

Top module: `pip_ctl_regbank`

## Requirements
- R1: A start condition followed by the address byte 0x24 is acknowledged as a write. The byte 0x25 is acknowledged as a read. Acknowledge means SDA is held low during the ninth clock.
- R2: Any other address byte is not acknowledged. All later bytes are also left unacknowledged and have no effect until the next start condition.
- R3: In a write, the second byte sets the register index and each later data byte is stored at that index. The index then increments, so a burst fills consecutive registers. Every byte is acknowledged.
- R4: Data bytes are kept in shadow storage. `regs_o` (register n at bits 8n+7:8n) changes only on the active vertical reference edge, and then it takes every shadow value at once.
- R5: The read byte is {pending, 5'b0, sync_lost_i, 1'b0}. Bit 7 is 1 from the first stored data byte until the next commit.
- R6: Indices 00h to 0Ch exist. A data byte aimed above 0Ch is acknowledged, discarded, and does not set the pending flag.
- R7: Live register 03h bit 6 selects the active vertical edge: 0 selects the rising edge and 1 selects the falling edge.
- R8: `h_pol_o` is live 03h bit 7 and `test_sel_o` is live 03h bits 2:0. `pip_en_o` is live 05h bit 0 and `pip_black_o` is live 05h bit 4.
- R9: While `rst_n` is low, all shadow and live registers and the pending flag are cleared, and SDA is released.
- R10: A start condition in the middle of a transfer releases SDA and restarts address reception. The index sent before it has no further effect.
- R11: The read byte is shifted out MSB first while SCL is low. It is sent again when the master acknowledges. SDA is released when the master does not acknowledge.
- R12: A stop condition releases SDA and returns the port to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_low_o | output | 1 | Pull the data line low when 1 |
| vref_i | input | 1 | Vertical reference pulse from the main picture |
| sync_lost_i | input | 1 | 1 when overlay horizontal pulses are absent or unlocked |
| regs_o | output | NUM_REGS*8 | Live register bank, register n at bits 8n+7:8n |
| h_pol_o | output | 1 | Horizontal reference polarity |
| v_pol_o | output | 1 | Vertical reference polarity |
| test_sel_o | output | 3 | Test output select |
| pip_en_o | output | 1 | Overlay enable |
| pip_black_o | output | 1 | Overlay forced to black |

## Verification
The bound checker watches several properties on every cycle:
- the live bank stays frozen unless a commit occurs;
- a stored byte raises the pending flag and a clean commit clears it;
- only in-range indices produce a store strobe;
- start and stop conditions release the data line.

Other behaviour depends on whole bus transfers, so only the bench scenarios can show it:
- address match and mismatch, the acknowledge pattern, and index auto-increment;
- discarding of out-of-range bytes;
- selection of the commit edge by polarity;
- status byte contents and repetition on a master acknowledge.

// File: rtl/pip_i2c_pkg.sv
package pip_i2c_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      BS_IDLE,
      BS_RX,
      BS_ACK,
      BS_TX,
      BS_TXACK,
      BS_IGNORE
   } bus_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_SUB,
      PH_DATA
   } byte_phase_t;

endpackage

// File: rtl/pip_line_sampler.sv
module pip_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic vref_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_s,
   output logic vref_rise,
   output logic vref_fall
);

   localparam logic [2:0] IDLE_V = 3'b011;  // vref low, sda high, scl high

   logic [2:0] in_v;
   logic [2:0] cur;
   logic [2:0] prv;

   assign in_v = {vref_i, sda_i, scl_i};

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 1");
   end

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      logic [2:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= IDLE_V;
            else        q <= in_v;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= IDLE_V;
            else        q <= g_stage[s-1].q;
         end
      end
   end

   assign cur = g_stage[SYNC_STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= IDLE_V;
      else        prv <= cur;
   end

   assign scl_rise  = cur[0] & ~prv[0];
   assign scl_fall  = ~cur[0] & prv[0];
   assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
   assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];
   assign sda_s     = cur[1];
   assign vref_rise = cur[2] & ~prv[2];
   assign vref_fall = ~cur[2] & prv[2];

endmodule

// File: rtl/pip_i2c_engine.sv
module pip_i2c_engine
   import pip_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h12,
   parameter int         NUM_REGS = 13,
   parameter int         SUB_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [BYTE_W-1:0] status_byte,
   output logic              sda_low,
   output logic              wr_en,
   output logic [SUB_W-1:0]  wr_sub,
   output logic [BYTE_W-1:0] wr_data
);

   localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NUM_REGS - 1);

   bus_state_t        state;
   byte_phase_t       phase;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txreg;
   logic [SUB_W-1:0]  sub;
   logic              rw_read;
   logic              m_acked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= BS_IDLE;
         phase   <= PH_ADDR;
         bitcnt  <= '0;
         shreg   <= '0;
         txreg   <= '0;
         sub     <= '0;
         rw_read <= 1'b0;
         m_acked <= 1'b0;
         sda_low <= 1'b0;
         wr_en   <= 1'b0;
         wr_sub  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state   <= BS_RX;
            phase   <= PH_ADDR;
            bitcnt  <= '0;
            sda_low <= 1'b0;
         end else if (stop_det) begin
            state   <= BS_IDLE;
            sda_low <= 1'b0;
         end else begin
            case (state)
               BS_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     case (phase)
                        PH_ADDR: begin
                           if (shreg[7:1] == DEV_ADDR) begin
                              rw_read <= shreg[0];
                              sda_low <= 1'b1;
                              state   <= BS_ACK;
                           end else begin
                              state   <= BS_IGNORE;
                           end
                        end
                        PH_SUB: begin
                           sub     <= SUB_W'(shreg);
                           phase   <= PH_DATA;
                           sda_low <= 1'b1;
                           state   <= BS_ACK;
                        end
                        default: begin
                           wr_en   <= (sub <= LAST_SUB);
                           wr_sub  <= sub;
                           wr_data <= shreg;
                           sub     <= sub + 1'b1;
                           sda_low <= 1'b1;
                           state   <= BS_ACK;
                        end
                     endcase
                  end
               end
               BS_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (phase == PH_ADDR && rw_read) begin
                        txreg   <= status_byte;
                        sda_low <= ~status_byte[7];
                        state   <= BS_TX;
                     end else begin
                        sda_low <= 1'b0;
                        if (phase == PH_ADDR) phase <= PH_SUB;
                        state <= BS_RX;
                     end
                  end
               end
               BS_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        sda_low <= 1'b0;
                        state   <= BS_TXACK;
                     end else begin
                        txreg   <= {txreg[BYTE_W-2:0], 1'b0};
                        sda_low <= ~txreg[BYTE_W-2];
                        bitcnt  <= bitcnt + 4'd1;
                     end
                  end
               end
               BS_TXACK: begin
                  if (scl_rise) begin
                     m_acked <= ~sda_s;
                  end else if (scl_fall) begin
                     if (m_acked) begin
                        txreg   <= status_byte;
                        sda_low <= ~status_byte[7];
                        bitcnt  <= '0;
                        state   <= BS_TX;
                     end else begin
                        state   <= BS_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/pip_shadow_bank.sv
module pip_shadow_bank
   import pip_i2c_pkg::*;
#(
   parameter int NUM_REGS = 13,
   parameter int SUB_W    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SUB_W-1:0]           wr_sub,
   input  logic [BYTE_W-1:0]          wr_data,
   input  logic                       commit,
   output logic [NUM_REGS*BYTE_W-1:0] live_flat,
   output logic                       pending
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [BYTE_W-1:0] shadow;
      logic [BYTE_W-1:0] live;
      logic              hit;

      assign hit = wr_en && (wr_sub == SUB_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow <= '0;
            live   <= '0;
         end else begin
            if (hit)    shadow <= wr_data;
            if (commit) live   <= shadow;
         end
      end

      assign live_flat[i*BYTE_W +: BYTE_W] = live;
   end

   // a store in the commit cycle keeps the flag set for the next commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pending <= 1'b0;
      else if (wr_en)  pending <= 1'b1;
      else if (commit) pending <= 1'b0;
   end

endmodule

// File: rtl/pip_ctl_regbank.sv
module pip_ctl_regbank
   import pip_i2c_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h12,
   parameter int         NUM_REGS    = 13,
   parameter int         SUB_W       = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   output logic                       sda_drive_low_o,
   input  logic                       vref_i,
   input  logic                       sync_lost_i,
   output logic [NUM_REGS*BYTE_W-1:0] regs_o,
   output logic                       h_pol_o,
   output logic                       v_pol_o,
   output logic [2:0]                 test_sel_o,
   output logic                       pip_en_o,
   output logic                       pip_black_o
);

   localparam int POL_REG  = 3;
   localparam int CTRL_REG = 5;

   if (NUM_REGS <= CTRL_REG || NUM_REGS > (1 << SUB_W)) begin : g_bad_regs
      $error("NUM_REGS must exceed the control register index and fit the index width");
   end

   logic              scl_rise, scl_fall, start_det, stop_det, sda_s;
   logic              vref_rise, vref_fall;
   logic              wr_en;
   logic [SUB_W-1:0]  wr_sub;
   logic [BYTE_W-1:0] wr_data;
   logic              commit;
   logic              pending;
   logic [BYTE_W-1:0] status_byte;
   logic [BYTE_W-1:0] pol_reg, ctrl_reg;

   pip_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .vref_i    (vref_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s),
      .vref_rise (vref_rise),
      .vref_fall (vref_fall)
   );

   assign status_byte = {pending, 5'b0, sync_lost_i, 1'b0};

   pip_i2c_engine #(
      .DEV_ADDR (DEV_ADDR),
      .NUM_REGS (NUM_REGS),
      .SUB_W    (SUB_W)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_det   (start_det),
      .stop_det    (stop_det),
      .sda_s       (sda_s),
      .status_byte (status_byte),
      .sda_low     (sda_drive_low_o),
      .wr_en       (wr_en),
      .wr_sub      (wr_sub),
      .wr_data     (wr_data)
   );

   pip_shadow_bank #(
      .NUM_REGS (NUM_REGS),
      .SUB_W    (SUB_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sub    (wr_sub),
      .wr_data   (wr_data),
      .commit    (commit),
      .live_flat (regs_o),
      .pending   (pending)
   );

   assign pol_reg  = regs_o[POL_REG*BYTE_W +: BYTE_W];
   assign ctrl_reg = regs_o[CTRL_REG*BYTE_W +: BYTE_W];

   assign commit      = pol_reg[6] ? vref_fall : vref_rise;
   assign h_pol_o     = pol_reg[7];
   assign v_pol_o     = pol_reg[6];
   assign test_sel_o  = pol_reg[2:0];
   assign pip_en_o    = ctrl_reg[0];
   assign pip_black_o = ctrl_reg[4];

endmodule

// File: rtl/pip_ctl_regbank_chk.sv
module pip_ctl_regbank_chk #(
   parameter int NUM_REGS = 13,
   parameter int SUB_W    = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_REGS*8-1:0] regs_o,
   input logic                  commit,
   input logic                  wr_en,
   input logic [SUB_W-1:0]      wr_sub,
   input logic                  pending,
   input logic                  start_det,
   input logic                  stop_det,
   input logic                  sda_drive_low_o
);

   localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(NUM_REGS - 1);

   p_live_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(regs_o));

   p_pending_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> pending);

   p_pending_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !wr_en) |=> !pending);

   p_store_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_sub <= LAST_SUB));

   p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_drive_low_o);

   p_stop_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_drive_low_o);

endmodule

bind pip_ctl_regbank pip_ctl_regbank_chk #(
   .NUM_REGS (NUM_REGS),
   .SUB_W    (SUB_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .regs_o          (regs_o),
   .commit          (commit),
   .wr_en           (wr_en),
   .wr_sub          (wr_sub),
   .pending         (pending),
   .start_det       (start_det),
   .stop_det        (stop_det),
   .sda_drive_low_o (sda_drive_low_o)
);

// File: tb/pip_ctl_regbank_tb.sv
`timescale 1ns/1ps
module pip_ctl_regbank_tb;

   localparam int NREG = 13;
   localparam int H    = 20;
   localparam int Q    = 10;

   typedef logic [7:0] byte_q_t[$];

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda_low = 1'b0;
   logic vref = 1'b0;
   logic sync_lost = 1'b0;
   logic sda_drive_low_o;
   logic [NREG*8-1:0] regs_o;
   logic h_pol_o, v_pol_o, pip_en_o, pip_black_o;
   logic [2:0] test_sel_o;
   wire  sda_line = ~(m_sda_low | sda_drive_low_o);

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   always #2.5 clk = ~clk;

   pip_ctl_regbank u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl),
      .sda_i           (sda_line),
      .sda_drive_low_o (sda_drive_low_o),
      .vref_i          (vref),
      .sync_lost_i     (sync_lost),
      .regs_o          (regs_o),
      .h_pol_o         (h_pol_o),
      .v_pol_o         (v_pol_o),
      .test_sel_o      (test_sel_o),
      .pip_en_o        (pip_en_o),
      .pip_black_o     (pip_black_o)
   );

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard: driver side pushes, monitor side pops as bus results appear
   task automatic sb_expect(input string tag, input int val);
      exp_q.push_back(val);
      tag_q.push_back(tag);
   endtask

   task automatic sb_observe(input int val);
      if (exp_q.size() == 0) begin
         n_run++; n_fail++;
         $display("FAIL scoreboard-empty actual=0x%0h expected=none", val);
      end else begin
         check(tag_q.pop_front(), val, exp_q.pop_front());
      end
   endtask

   function automatic int reg_at(input int i);
      return int'(regs_o[i*8 +: 8]);
   endfunction

   task automatic bus_start();
      m_sda_low = 1'b0; wclk(Q);
      scl = 1'b1;       wclk(H);
      m_sda_low = 1'b1; wclk(H);
      scl = 1'b0;       wclk(Q);
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1; wclk(Q);
      scl = 1'b1;       wclk(H);
      m_sda_low = 1'b0; wclk(H);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = ~b[i]; wclk(Q);
         scl = 1'b1;        wclk(H);
         scl = 1'b0;        wclk(Q);
      end
      m_sda_low = 1'b0; wclk(Q);
      scl = 1'b1;       wclk(Q);
      sb_observe(sda_line ? 1 : 0);
      wclk(Q);
      scl = 1'b0;       wclk(Q);
   endtask

   task automatic read_byte(input logic m_ack);
      logic [7:0] v = '0;
      m_sda_low = 1'b0;
      for (int i = 0; i < 8; i++) begin
         wclk(Q);
         scl = 1'b1; wclk(Q);
         v = {v[6:0], sda_line};
         wclk(Q);
         scl = 1'b0; wclk(Q);
      end
      sb_observe(int'(v));
      m_sda_low = m_ack; wclk(Q);
      scl = 1'b1;        wclk(H);
      scl = 1'b0;        wclk(Q);
      m_sda_low = 1'b0;
   endtask

   task automatic write_burst(input logic [7:0] sub, input byte_q_t data, input string tag);
      bus_start();
      sb_expect("R1 write address ack", 0);
      send_byte(8'h24);
      sb_expect({tag, " index ack"}, 0);
      send_byte(sub);
      foreach (data[k]) begin
         sb_expect({tag, " data ack"}, 0);
         send_byte(data[k]);
      end
      bus_stop();
   endtask

   task automatic read_status(input int n, input int exp, input string tag);
      bus_start();
      sb_expect("R1 read address ack", 0);
      send_byte(8'h25);
      for (int k = 0; k < n; k++) begin
         sb_expect(tag, exp);
         read_byte(k < n - 1);
      end
      bus_stop();
   endtask

   task automatic vpulse();
      vref = 1'b1; wclk(8);
      vref = 1'b0; wclk(8);
   endtask

   initial begin
      logic [NREG*8-1:0] snap;
      wclk(5);
      check("R9 live bank cleared", int'(regs_o != '0), 0);
      check("R9 sda released in reset", int'(sda_drive_low_o), 0);
      rst_n = 1'b1;
      wclk(5);

      read_status(1, 8'h00, "R5 status after reset");

      // burst of three into 03h..05h
      write_burst(8'h03, '{8'h85, 8'h20, 8'h11}, "R3");
      check("R4 live unchanged before commit", int'(regs_o != '0), 0);
      read_status(1, 8'h80, "R5 pending set");
      sync_lost = 1'b1;
      read_status(1, 8'h82, "R5 pending and sync lost");
      vpulse();
      check("R3 reg03 stored", reg_at(3), 8'h85);
      check("R3 reg04 auto-increment", reg_at(4), 8'h20);
      check("R3 reg05 auto-increment", reg_at(5), 8'h11);
      check("R4 reg06 untouched", reg_at(6), 0);
      check("R8 h_pol", int'(h_pol_o), 1);
      check("R8 test_sel", int'(test_sel_o), 5);
      check("R8 pip_en", int'(pip_en_o), 1);
      check("R8 pip_black", int'(pip_black_o), 1);
      check("R7 v_pol", int'(v_pol_o), 0);
      read_status(1, 8'h02, "R5 pending cleared by commit");
      sync_lost = 1'b0;

      // foreign address
      snap = regs_o;
      bus_start();
      sb_expect("R2 foreign address nack", 1);
      send_byte(8'h30);
      sb_expect("R2 following byte nack", 1);
      send_byte(8'h05);
      bus_stop();
      vpulse();
      check("R2 bank unchanged", int'(regs_o != snap), 0);
      read_status(1, 8'h00, "R2 no pending after foreign address");

      // top index and beyond
      write_burst(8'h0C, '{8'h03, 8'hAA}, "R6");
      read_status(1, 8'h80, "R6 pending from in-range byte");
      vpulse();
      check("R6 reg0C stored", reg_at(12), 8'h03);
      check("R6 reg00 not hit by overflow", reg_at(0), 0);
      snap = regs_o;
      write_burst(8'h0D, '{8'h55}, "R6 beyond range");
      read_status(1, 8'h00, "R6 discarded byte leaves pending clear");
      vpulse();
      check("R6 bank unchanged by discarded byte", int'(regs_o != snap), 0);

      // vertical polarity
      write_burst(8'h03, '{8'h40}, "R7");
      vpulse();
      check("R7 v_pol set", int'(v_pol_o), 1);
      check("R8 h_pol cleared", int'(h_pol_o), 0);
      write_burst(8'h00, '{8'h5A}, "R7");
      vref = 1'b1; wclk(8);
      check("R7 rising edge ignored when negative", reg_at(0), 0);
      vref = 1'b0; wclk(8);
      check("R7 falling edge commits", reg_at(0), 8'h5A);

      // repeated start in mid transfer
      bus_start();
      sb_expect("R10 address ack", 0);
      send_byte(8'h24);
      sb_expect("R10 index ack", 0);
      send_byte(8'h01);
      bus_start();
      check("R10 sda released after start", int'(sda_drive_low_o), 0);
      sb_expect("R10 address ack after restart", 0);
      send_byte(8'h24);
      sb_expect("R10 index ack after restart", 0);
      send_byte(8'h02);
      sb_expect("R10 data ack after restart", 0);
      send_byte(8'h77);
      bus_stop();
      vpulse();
      check("R10 reg02 written", reg_at(2), 8'h77);
      check("R10 reg01 untouched", reg_at(1), 0);

      // repeated read with ack then nack
      sync_lost = 1'b1;
      read_status(2, 8'h02, "R11 status repeated on master ack");
      check("R11 sda released after nack", int'(sda_drive_low_o), 0);
      check("R12 line high after stop", int'(sda_line), 1);
      sync_lost = 1'b0;

      if (exp_q.size() != 0) begin
         n_run++; n_fail++;
         $display("FAIL scoreboard-leftover actual=%0d expected=0", exp_q.size());
      end

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule